// File: doc/BRIEF.md
# Bit and Byte Manipulation Execution Unit

This unit is one pipeline stage for a group of scalar bit and byte rearranging operations on register-width data. The width `XLEN` is 32 or 64. A 3-bit opcode picks the operation for the cycle. Each operation reads some of these inputs:

- operand inputs A, B and a mask C,
- the old destination value,
- a 6-bit amount field,
- a separate 64-bit wide source.

The result is computed combinationally and captured in an output register. That register raises a valid flag one clock after a valid request.

The caller decodes instructions and fetches registers. For the word-extract operation it also assembles the 64-bit wide source. In a 32-bit core this means joining a register pair, with the odd register as the upper half and the even register as the lower half. The unit never reads a register file itself. The unit stalls nothing, so a new request can be issued on every clock.

Top module: `bitmanip_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next output state has `res_valid` = 0 and `res_data` = 0. This holds even if `in_valid` is high in the same cycle.
- R2: When `in_valid` is high at a rising edge (and no reset), `res_valid` is 1 after that edge and `res_data` holds the operation result. When `in_valid` is low, `res_valid` goes to 0 and `res_data` keeps its previous value.
- R3: Opcode 0 (reverse): let m be `amt[4:0]` for XLEN=32 or `amt[5:0]` for XLEN=64. Result bit i equals `src_a[m-i]` for i <= m. All bits above m are 0.
- R4: Opcode 1 (byte insert): the result is `dst_old` with byte number p replaced by `src_a[7:0]`. Here p is `amt[1:0]` for XLEN=32 or `amt[2:0]` for XLEN=64.
- R5: Opcode 2 (pick): each result bit takes the `src_a` bit where the `src_c` bit is 1, and the `src_b` bit where it is 0.
- R6: Opcode 3 (byte swap): inside every 16-bit halfword of `src_a`, the upper and lower bytes trade places.
- R7: Opcode 4 (halfword swap): inside every 32-bit word of `src_a`, the upper and lower halfwords trade places.
- R8: Opcode 5 (word extract): the 32-bit field `src_wide[lsb+31:lsb]` is returned, with lsb = `amt[4:0]`. For XLEN=64 it is sign-extended from its bit 31. For XLEN=32 it is returned unchanged.
- R9: Opcodes 6 and 7 give a zero result, and `res_valid` is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation select |
| src_a | input | XLEN | Primary operand |
| src_b | input | XLEN | Second operand for pick |
| src_c | input | XLEN | Bit mask for pick |
| dst_old | input | XLEN | Old destination value for byte insert |
| amt | input | 6 | Reverse msb, insert byte position or extract offset |
| src_wide | input | 64 | 64-bit source for word extract |
| res_valid | output | 1 | Result register holds a fresh result |
| res_data | output | XLEN | Registered result |

## Verification
Reset and a new request can arrive on the same clock edge. The bench provokes this by holding `in_valid` high with a byte-insert request while `rst` is asserted. It then checks that the register comes out cleared, not loaded. A second overlap is a request that is dropped (`in_valid` low) while the operands keep changing. Here the bench checks that `res_valid` falls and `res_data` keeps the last result. Every offset of reverse and extract and every insert position is swept. Each result is compared with a value the bench computes arithmetically.

// File: rtl/bitmanip_unit.sv
module bitmanip_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] src_c,
  input  logic [XLEN-1:0] dst_old,
  input  logic [5:0]      amt,
  input  logic [63:0]     src_wide,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data
);
  localparam int AW = $clog2(XLEN);
  localparam int BW = $clog2(XLEN / 8);

  wire [AW-1:0] msb  = amt[AW-1:0];
  wire [BW-1:0] bpos = amt[BW-1:0];
  wire [4:0]    lsb  = amt[4:0];

  logic [XLEN-1:0] rev_r, ins_r, sw8_r, sw16_r, ext_r, nxt;
  wire  [XLEN-1:0] pick_r = (src_a & src_c) | (src_b & ~src_c);

  always_comb begin
    logic [AW-1:0] k;
    for (int i = 0; i < XLEN; i++) begin
      k = msb - AW'(i);
      rev_r[i] = (AW'(i) <= msb) ? src_a[k] : 1'b0;
    end
  end

  always_comb begin
    ins_r = dst_old;
    ins_r[{bpos, 3'b000} +: 8] = src_a[7:0];
  end

  for (genvar h = 0; h < XLEN / 16; h++) begin : g_sw8
    assign sw8_r[16*h +: 16] = {src_a[16*h +: 8], src_a[16*h+8 +: 8]};
  end

  for (genvar w = 0; w < XLEN / 32; w++) begin : g_sw16
    assign sw16_r[32*w +: 32] = {src_a[32*w +: 16], src_a[32*w+16 +: 16]};
  end

  wire [63:0] shifted = src_wide >> lsb;
  if (XLEN == 64) begin : g_ext64
    assign ext_r = {{32{shifted[31]}}, shifted[31:0]};
  end else begin : g_ext32
    assign ext_r = shifted[XLEN-1:0];
  end

  always_comb begin
    case (op)
      3'd0:    nxt = rev_r;
      3'd1:    nxt = ins_r;
      3'd2:    nxt = pick_r;
      3'd3:    nxt = sw8_r;
      3'd4:    nxt = sw16_r;
      3'd5:    nxt = ext_r;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_data <= nxt;
    end
  end
endmodule

// File: rtl/bitmanip_unit_chk.sv
module bitmanip_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [2:0]      op,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [XLEN-1:0] src_c,
  input logic            res_valid,
  input logic [XLEN-1:0] res_data
);
  logic prev_rst;
  always_ff @(posedge clk) prev_rst <= rst;

  // R1
  always @(negedge clk)
    if (prev_rst) reset_clear_chk: assert (!res_valid && res_data == '0);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  // R2
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_data));

  // R5
  pick_mux_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd2) |=>
      res_data == (($past(src_a) & $past(src_c)) | ($past(src_b) & ~$past(src_c))));

  // R9
  unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[2:1] == 2'b11) |=> (res_valid && res_data == '0));
endmodule

bind bitmanip_unit bitmanip_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
  .src_a(src_a), .src_b(src_b), .src_c(src_c),
  .res_valid(res_valid), .res_data(res_data)
);

// File: tb/test_bitmanip_unit.sv
module test_bitmanip_unit;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [2:0]      op = '0;
  logic [XLEN-1:0] src_a = '0, src_b = '0, src_c = '0, dst_old = '0;
  logic [5:0]      amt = '0;
  logic [63:0]     src_wide = '0;
  logic            res_valid;
  logic [XLEN-1:0] res_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  bitmanip_unit #(.XLEN(XLEN)) i_bitmanip_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .dst_old(dst_old),
    .amt(amt), .src_wide(src_wide), .res_valid(res_valid), .res_data(res_data)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] nextr(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic check(input string req, input logic v, input logic [XLEN-1:0] d,
                       input logic ev, input logic [XLEN-1:0] ed);
    checks++;
    if (v !== ev || d !== ed) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h", req, v, d, ev, ed);
    end
  endtask

  task automatic run(input string req, input logic [2:0] o, input logic [XLEN-1:0] a,
                     input logic [XLEN-1:0] b, input logic [XLEN-1:0] c,
                     input logic [XLEN-1:0] d, input logic [5:0] m,
                     input logic [63:0] w, input logic [XLEN-1:0] exp);
    @(negedge clk);
    in_valid = 1'b1; op = o; src_a = a; src_b = b; src_c = c;
    dst_old = d; amt = m; src_wide = w;
    @(negedge clk);
    check(req, res_valid, res_data, 1'b1, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: valid=%0b data=%h expected completion", res_valid, res_data);
    finish_run();
  end

  initial begin
    logic [XLEN-1:0] a, b, c, d, e, last;
    logic [63:0] w;
    in_valid = 1'b1; op = 3'd1; src_a = 32'hFF; dst_old = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    // R1: reset with a live request
    check("R1", res_valid, res_data, 1'b0, '0);
    rst = 1'b0; in_valid = 1'b0;

    // R3: every msb, several patterns
    for (int m = 0; m < XLEN; m++)
      for (int p = 0; p < 4; p++) begin
        seed = nextr(seed);
        a = (p == 0) ? '1 : (p == 1) ? 32'h0000_0001 : seed;
        e = {<<{a}} >> (XLEN - 1 - m);
        run("R3", 3'd0, a, '0, '0, '0, 6'(m), '0, e);
      end

    // R4: every byte position, high amt bits ignored
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++) begin
        seed = nextr(seed); a = seed; seed = nextr(seed); d = seed;
        e = d;
        e[8*p +: 8] = a[7:0];
        run("R4", 3'd1, a, '0, '0, d, 6'(p + 4 * k), '0, e);
      end

    // R5
    for (int k = 0; k < 24; k++) begin
      seed = nextr(seed); a = seed; seed = nextr(seed); b = seed;
      seed = nextr(seed);
      c = (k == 0) ? '0 : (k == 1) ? '1 : seed;
      e = '0;
      for (int i = 0; i < XLEN; i++) e[i] = c[i] ? a[i] : b[i];
      run("R5", 3'd2, a, b, c, '0, '0, '0, e);
    end

    // R6 and R7
    for (int k = 0; k < 16; k++) begin
      seed = nextr(seed); a = seed;
      e = ((a & 32'h00FF_00FF) << 8) | ((a >> 8) & 32'h00FF_00FF);
      run("R6", 3'd3, a, '0, '0, '0, '0, '0, e);
      e = (a << 16) | (a >> 16);
      run("R7", 3'd4, a, '0, '0, '0, '0, '0, e);
    end

    // R8: every offset, amt bit 5 ignored
    for (int l = 0; l < 32; l++)
      for (int k = 0; k < 3; k++) begin
        seed = nextr(seed); w[63:32] = seed; seed = nextr(seed); w[31:0] = seed;
        if (k == 0) w = 64'hFFFF_FFFF_0000_0000;
        e = XLEN'((w / (64'd1 << l)) % (64'd1 << 32));
        run("R8", 3'd5, '0, '0, '0, '0, 6'(l + 32 * (k % 2)), w, e);
      end

    // R9
    run("R9", 3'd6, '1, '1, '1, '1, 6'h3F, '1, '0);
    run("R9", 3'd7, '1, '1, '1, '1, 6'h3F, '1, '0);

    // R2: drop a request, data holds while inputs change
    run("R2", 3'd4, 32'h1234_ABCD, '0, '0, '0, '0, '0, 32'hABCD_1234);
    last = 32'hABCD_1234;
    @(negedge clk);
    in_valid = 1'b0; op = 3'd0; src_a = 32'hFFFF_FFFF; amt = 6'd31;
    @(negedge clk);
    check("R2", res_valid, res_data, 1'b0, last);
    src_a = 32'h5555_0000;
    @(negedge clk);
    check("R2", res_valid, res_data, 1'b0, last);

    // R1: reset again while a request is held high
    in_valid = 1'b1; op = 3'd1; src_a = 32'hAA; rst = 1'b1;
    @(negedge clk);
    check("R1", res_valid, res_data, 1'b0, '0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule